// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a register datapath and a 32-bit data memory port whose byte order is big-endian. The smallest byte address within a word holds the most significant byte, so offset 0 maps to data bits 31:24. On the store side it takes a transfer size, a byte offset and the source register value. It returns one registered cycle later with per-byte write enables and a write word in which the wanted bits stand in every lane that could be enabled.

On the load side it takes the word returned by memory together with the size, offset and a signed flag. One cycle later it delivers a 32-bit result. That result is a whole word, or a byte or halfword taken from the addressed lane and sign- or zero-extended. The store path and the load path are independent, and both may be active in the same cycle.

Size codes are 00 for byte, 01 for halfword, and 10 or 11 for word. Halfword accesses are assumed to use even offsets, and offset bit 0 is not looked at for them. Address generation, traps on misaligned accesses and wider transfers belong to other blocks.

Top module: `lsa_top`

## Requirements
- R1: While rst_n is low at a clock edge, mem_wr, mem_we, mem_wdata, ld_done and ld_result all become zero.
- R2: A byte store (st_size 00) drives exactly one write-enable bit, mem_we[3 - offset], so offset 0 enables the lane on bits 31:24.
- R3: A byte store puts st_data[7:0] on all four byte lanes of mem_wdata.
- R4: A halfword store (st_size 01) enables 4'b1100 when offset bit 1 is 0 and 4'b0011 when it is 1, ignores offset bit 0, and drives {st_data[15:0], st_data[15:0]}.
- R5: A word store (st_size 10 or 11) enables all four lanes and passes st_data unchanged, whatever the offset.
- R6: In the cycle after st_valid is low, mem_wr is 0 and mem_we is 4'b0000.
- R7: A signed byte load returns the byte on bits (31-8*offset) down to (24-8*offset) of ld_word, with its top bit copied into result bits 31:8.
- R8: An unsigned byte load (ld_signed 0) returns the same byte with result bits 31:8 zero.
- R9: A halfword load takes ld_word[31:16] when offset bit 1 is 0 and ld_word[15:0] when it is 1. It sign-extends when ld_signed is 1 and zero-extends otherwise.
- R10: A word load returns ld_word unchanged, whatever the offset or the ld_signed flag.
- R11: In the cycle after ld_valid is low, ld_done is 0 and ld_result keeps its previous value.
- R12: Both paths have one cycle of latency. A store request and a load response presented at the same edge both appear, unchanged by each other, at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_size | input | 2 | Store size: 00 byte, 01 half, 1x word |
| st_offset | input | 2 | Byte offset within the word |
| st_data | input | 32 | Source register value |
| mem_wr | output | 1 | Registered write strobe |
| mem_we | output | 4 | Per-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered write word |
| ld_valid | input | 1 | Load response present |
| ld_size | input | 2 | Load size: 00 byte, 01 half, 1x word |
| ld_signed | input | 1 | 1 = sign-extend, 0 = zero-extend |
| ld_offset | input | 2 | Byte offset within the word |
| ld_word | input | 32 | Word returned by memory |
| ld_done | output | 1 | Result valid |
| ld_result | output | 32 | Extracted and extended value |

## Verification
A store request and a load response can land in the same cycle. The bench presents both on every step of its sweep over each size code, each offset, both signedness values and several data patterns. Each output group is compared on the following cycle with values worked out arithmetically from shifts and masks. Mixing the two paths this way would expose any crosstalk between them. Idle steps with new data on the inputs follow, to show that the enables drop and the load result holds.

// File: rtl/lsa_pkg.sv
// Package: shared size encoding for the load/store lane aligner.
// Assumes a 2-bit size field; code 2'b11 behaves as a word.
package lsa_pkg;
    typedef enum logic [1:0] {
        XS_BYTE = 2'b00,
        XS_HALF = 2'b01,
        XS_WORD = 2'b10,
        XS_WRD2 = 2'b11
    } xfer_size_t;
endpackage

// File: rtl/lsa_store_lane.sv
// Store lane steering: builds per-lane write enables and the replicated
// write word. Lane 0 is the most significant lane (lowest byte address).
// Assumes halfword accesses use even offsets.
module lsa_store_lane #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFF_W = $clog2(LANES),
    localparam int HALF_W = 2 * BYTE_W
) (
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  we,
    output logic [DATA_W-1:0] wdata
);
    import lsa_pkg::*;

    logic is_byte;
    logic is_half;

    // Purpose: decode the size field.
    always_comb begin
        is_byte = (size == XS_BYTE);
        is_half = (size == XS_HALF);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HI = DATA_W - 1 - i * BYTE_W;
        localparam int HALF_IDX = i / 2;
        localparam int SUB = i % 2;

        // Purpose: lane enable and lane data for lane i.
        always_comb begin
            if (is_byte) begin
                we[LANES-1-i] = (int'(offset) == i);
                wdata[HI -: BYTE_W] = data[BYTE_W-1:0];
            end else if (is_half) begin
                we[LANES-1-i] = (int'(offset[OFF_W-1:1]) == HALF_IDX);
                wdata[HI -: BYTE_W] = data[HALF_W-1-SUB*BYTE_W -: BYTE_W];
            end else begin
                we[LANES-1-i] = 1'b1;
                wdata[HI -: BYTE_W] = data[HI -: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/lsa_load_extract.sv
// Load extraction: picks a byte, halfword or word out of a big-endian
// memory word and extends it to full width. Offset 0 selects the most
// significant lane. Assumes halfword accesses use even offsets.
module lsa_load_extract #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFF_W = $clog2(LANES),
    localparam int HALF_W = 2 * BYTE_W
) (
    input  logic [1:0]        size,
    input  logic              sign_en,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] result
);
    import lsa_pkg::*;

    logic [BYTE_W-1:0] byte_v;
    logic [HALF_W-1:0] half_v;
    logic              byte_fill;
    logic              half_fill;

    // Purpose: select the addressed byte and halfword lanes.
    always_comb begin
        byte_v = word[DATA_W - 1 - int'(offset) * BYTE_W -: BYTE_W];
        half_v = word[DATA_W - 1 - int'(offset[OFF_W-1:1]) * HALF_W -: HALF_W];
    end

    // Purpose: compute the extension fill bit for each size.
    always_comb begin
        byte_fill = sign_en & byte_v[BYTE_W-1];
        half_fill = sign_en & half_v[HALF_W-1];
    end

    // Purpose: assemble the extended result by size.
    always_comb begin
        unique case (size)
            XS_BYTE: result = {{(DATA_W-BYTE_W){byte_fill}}, byte_v};
            XS_HALF: result = {{(DATA_W-HALF_W){half_fill}}, half_v};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lsa_top.sv
// Big-endian load/store lane aligner top. Registers the store-side
// enables and write word, and the load-side result, each one cycle after
// the request. The two paths share nothing but clock and reset.
module lsa_top #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [1:0]        st_size,
    input  logic [OFF_W-1:0]  st_offset,
    input  logic [DATA_W-1:0] st_data,
    output logic              mem_wr,
    output logic [LANES-1:0]  mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              ld_valid,
    input  logic [1:0]        ld_size,
    input  logic              ld_signed,
    input  logic [OFF_W-1:0]  ld_offset,
    input  logic [DATA_W-1:0] ld_word,
    output logic              ld_done,
    output logic [DATA_W-1:0] ld_result
);
    logic [LANES-1:0]  st_we_c;
    logic [DATA_W-1:0] st_wd_c;
    logic [DATA_W-1:0] ld_res_c;

    lsa_store_lane #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_store (
        .size   (st_size),
        .offset (st_offset),
        .data   (st_data),
        .we     (st_we_c),
        .wdata  (st_wd_c)
    );

    lsa_load_extract #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_load (
        .size    (ld_size),
        .sign_en (ld_signed),
        .offset  (ld_offset),
        .word    (ld_word),
        .result  (ld_res_c)
    );

    // Purpose: register the store strobe, enables and write word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr    <= 1'b0;
            mem_we    <= '0;
            mem_wdata <= '0;
        end else begin
            mem_wr <= st_valid;
            mem_we <= st_valid ? st_we_c : '0;
            if (st_valid) begin
                mem_wdata <= st_wd_c;
            end
        end
    end

    // Purpose: register the load result, holding it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_done   <= 1'b0;
            ld_result <= '0;
        end else begin
            ld_done <= ld_valid;
            if (ld_valid) begin
                ld_result <= ld_res_c;
            end
        end
    end
endmodule

// File: rtl/lsa_checker.sv
// Checker for lsa_top: relates registered outputs to the inputs of the
// previous cycle. Attached with the bind statement at the end of the file.
module lsa_checker #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        st_size,
    input logic [DATA_W-1:0] st_data,
    input logic              mem_wr,
    input logic [LANES-1:0]  mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              ld_done,
    input logic [DATA_W-1:0] ld_result
);
    a_r6_idle_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr |-> (mem_we == '0));

    a_r2_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(st_size) == 2'b00) |-> ($countones(mem_we) == 1));

    a_r3_byte_replicated: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(st_size) == 2'b00)
            |-> (mem_wdata == {LANES{$past(st_data[BYTE_W-1:0])}}));

    a_r4_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(st_size) == 2'b01)
            |-> (mem_we == 4'b1100 || mem_we == 4'b0011));

    a_r5_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(st_size[1])) |-> (mem_we == '1 && mem_wdata == $past(st_data)));

    a_r11_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ld_done) |-> $stable(ld_result));
endmodule

bind lsa_top lsa_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_size   (st_size),
    .st_data   (st_data),
    .mem_wr    (mem_wr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .ld_done   (ld_done),
    .ld_result (ld_result)
);

// File: tb/lsa_top_bench.sv
module lsa_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        st_valid;
    logic [1:0]  st_size;
    logic [1:0]  st_offset;
    logic [31:0] st_data;
    logic        mem_wr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        ld_valid;
    logic [1:0]  ld_size;
    logic        ld_signed;
    logic [1:0]  ld_offset;
    logic [31:0] ld_word;
    logic        ld_done;
    logic [31:0] ld_result;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsa_top u_lsa_top (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_size(st_size), .st_offset(st_offset), .st_data(st_data),
        .mem_wr(mem_wr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .ld_valid(ld_valid), .ld_size(ld_size), .ld_signed(ld_signed),
        .ld_offset(ld_offset), .ld_word(ld_word),
        .ld_done(ld_done), .ld_result(ld_result)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_we(input int sz, input int off);
        if (sz == 0) return 4'b1000 >> off;
        if (sz == 1) return (off >= 2) ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_wd(input int sz, input logic [31:0] d);
        if (sz == 0) return {4{d[7:0]}};
        if (sz == 1) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] exp_ld(input int sz, input int off, input bit sg,
                                           input logic [31:0] w);
        logic [31:0] v;
        if (sz == 0) begin
            v = (w >> ((3 - off) * 8)) & 32'hFF;
            if (sg && v[7]) v = v | 32'hFFFF_FF00;
            return v;
        end
        if (sz == 1) begin
            v = (off >= 2) ? (w & 32'hFFFF) : (w >> 16);
            if (sg && v[15]) v = v | 32'hFFFF_0000;
            return v;
        end
        return w;
    endfunction

    function automatic string ld_tag(input int sz, input bit sg);
        if (sz == 0) return sg ? "R7" : "R8";
        if (sz == 1) return "R9";
        return "R10";
    endfunction

    function automatic string st_tag(input int sz);
        if (sz == 0) return "R2";
        if (sz == 1) return "R4";
        return "R5";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] pats [4];
        logic [31:0] last_res;
        pats[0] = 32'h80FF_7F01;
        pats[1] = 32'h7F80_017E;
        pats[2] = 32'hDEAD_BEEF;
        pats[3] = 32'h0123_4567;

        rst_n = 1'b0;
        st_valid = 1'b1; st_size = 2'b10; st_offset = 2'd0; st_data = 32'hFFFF_FFFF;
        ld_valid = 1'b1; ld_size = 2'b10; ld_signed = 1'b1; ld_offset = 2'd0;
        ld_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R1: reset state despite valid inputs
        check("R1 mem_wr", {31'd0, mem_wr}, 32'd0);
        check("R1 mem_we", {28'd0, mem_we}, 32'd0);
        check("R1 mem_wdata", mem_wdata, 32'd0);
        check("R1 ld_done", {31'd0, ld_done}, 32'd0);
        check("R1 ld_result", ld_result, 32'd0);
        rst_n = 1'b1;
        last_res = 32'd0;

        // R12: store and load presented together on every step of the sweep
        for (int p = 0; p < 4; p++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int off = 0; off < 4; off++) begin
                    for (int sg = 0; sg < 2; sg++) begin
                        st_valid = 1'b1; st_size = 2'(sz); st_offset = 2'(off);
                        st_data = pats[p] ^ {16'd0, 8'(sg), 8'd0};
                        ld_valid = 1'b1; ld_size = 2'(sz); ld_signed = sg[0];
                        ld_offset = 2'(3 - off); ld_word = pats[3 - p];
                        @(negedge clk);
                        check("R12 mem_wr", {31'd0, mem_wr}, 32'd1);
                        check("R12 ld_done", {31'd0, ld_done}, 32'd1);
                        check(st_tag(sz), {28'd0, mem_we}, {28'd0, exp_we(sz, off)});
                        check(sz == 0 ? "R3" : st_tag(sz), mem_wdata, exp_wd(sz, st_data));
                        check(ld_tag(sz, sg[0]), ld_result,
                              exp_ld(sz, 3 - off, sg[0], pats[3 - p]));
                        last_res = exp_ld(sz, 3 - off, sg[0], pats[3 - p]);
                    end
                end
            end
        end

        // R6 R11: idle steps with changing data
        for (int k = 0; k < 4; k++) begin
            st_valid = 1'b0; st_size = 2'(k); st_offset = 2'(k); st_data = pats[k];
            ld_valid = 1'b0; ld_size = 2'(k); ld_offset = 2'(k); ld_word = ~pats[k];
            @(negedge clk);
            check("R6 mem_wr", {31'd0, mem_wr}, 32'd0);
            check("R6 mem_we", {28'd0, mem_we}, 32'd0);
            check("R11 ld_done", {31'd0, ld_done}, 32'd0);
            check("R11 ld_result", ld_result, last_res);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule